// File: doc/BRIEF.md
# Single-Step Non-Restoring Divide Unit

This block carries out one step of non-restoring binary division per command, the way a processor datapath executes a divide-step instruction. It keeps three status flags: Q (the running remainder-sign bit), M (the divisor-sign bit) and T (the quotient bit of the latest step). It takes a partial remainder and a divisor from the surrounding register file. Each step shifts the remainder left and feeds T in as the new low bit. It then adds or subtracts the divisor, chosen by the previous Q and by M, and returns the updated remainder through a register together with the new flags.

Two initialisation commands prepare the flags for unsigned or signed division. A rotate-through-T command moves the quotient register one place left. It sends the register's top bit into T and brings the old T in at the bottom. Interleaving rotates and steps, 32 of each plus one final rotate, turns a dividend held in the quotient register into the unsigned quotient. The caller stores every returned value back into its own register file between commands.

Top module: `divstep_unit`

## Requirements
- R1: After reset, rem_out, flag_q, flag_m and flag_t are all zero.
- R2: A command with cmd_code 1 (init-unsigned) clears Q, M and T in the next cycle and leaves rem_out unchanged.
- R3: A command with cmd_code 2 (init-signed) sets Q to rem_in[W-1], M to dvsr_in[W-1] and T to Q XOR M in the next cycle, and leaves rem_out unchanged.
- R4: A command with cmd_code 0 (step) first forms S = {rem_in[W-2:0], T}. In the next cycle rem_out is S minus dvsr_in when the Q held before the step equals M, and S plus dvsr_in otherwise, modulo 2^W.
- R5: After a step, Q equals rem_in[W-1] XOR C XOR M. For a subtraction, C is the borrow (S < dvsr_in as unsigned). For an addition, C is the carry out of the W-bit sum.
- R6: After a step, T is 1 exactly when the new Q equals M, and M is unchanged.
- R7: A command with cmd_code 3 (rotate) makes rem_out = {rem_in[W-2:0], T} and T = rem_in[W-1] in the next cycle, with Q and M unchanged.
- R8: While cmd_valid is low, rem_out and all three flags hold their values whatever the other inputs do.
- R9: Starting from init-unsigned with a zero remainder and the dividend in the quotient register, the sequence of 32 rotate/step pairs followed by one rotate leaves floor(dividend / divisor) in the quotient register for any non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe; one command per cycle while high |
| cmd_code | input | 2 | 0 step, 1 init-unsigned, 2 init-signed, 3 rotate through T |
| rem_in | input | W | Partial remainder (step), dividend (init-signed) or quotient register (rotate) |
| dvsr_in | input | W | Divisor |
| rem_out | output | W | Registered result of the last step or rotate |
| flag_q | output | 1 | Q flag |
| flag_m | output | 1 | M flag |
| flag_t | output | 1 | T flag (quotient bit / rotate carry) |

## Verification
A wrong Q or T does not stay hidden. T enters the next shifted remainder as its low bit, and Q decides the next add-or-subtract, so a single bad step shows up at rem_out one command later and spoils every later quotient bit. The bench keeps a behavioural model of the remainder and the flags and compares them at the ports after every command. A disagreement is therefore reported in the cycle it appears, before it can spread. Full unsigned divisions then confirm that the flags and remainder combine into the correct quotient over 65 commands.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

   // Command encoding presented on cmd_code
   typedef enum logic [1:0] {
      CMD_STEP   = 2'd0,
      CMD_INIT_U = 2'd1,
      CMD_INIT_S = 2'd2,
      CMD_ROT    = 2'd3
   } dstep_cmd_e;

   // Carry detection variants for the add/subtract stage
   localparam int CARRY_WIDE_ADDER = 0;
   localparam int CARRY_COMPARE    = 1;

endpackage

// File: rtl/divstep_shifter.sv
module divstep_shifter #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   input  logic         fill_bit,
   output logic [W-1:0] dout,
   output logic         lost_bit
);
   assign dout     = {din[W-2:0], fill_bit};
   assign lost_bit = din[W-1];
endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
   parameter int W          = 32,
   parameter int CARRY_MODE = divstep_pkg::CARRY_WIDE_ADDER
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         do_sub,
   output logic [W-1:0] result,
   output logic         carry
);
   generate
      if (CARRY_MODE == divstep_pkg::CARRY_WIDE_ADDER) begin : g_wide
         logic [W:0] wide;
         always_comb begin
            if (do_sub) wide = {1'b0, opa} - {1'b0, opb};
            else        wide = {1'b0, opa} + {1'b0, opb};
         end
         assign result = wide[W-1:0];
         assign carry  = wide[W];
      end else if (CARRY_MODE == divstep_pkg::CARRY_COMPARE) begin : g_cmp
         always_comb begin
            if (do_sub) begin
               result = opa - opb;
               carry  = (result > opa);
            end else begin
               result = opa + opb;
               carry  = (result < opa);
            end
         end
      end else begin : g_bad_mode
         $error("divstep_addsub: unsupported CARRY_MODE");
      end
   endgenerate
endmodule

// File: rtl/divstep_flags.sv
module divstep_flags (
   input  logic m_in,
   input  logic lost_bit,
   input  logic carry,
   output logic q_next,
   output logic t_next
);
   // Carry sense flips with the divisor sign; the quotient bit is Q==M.
   assign q_next = lost_bit ^ carry ^ m_in;
   assign t_next = ~(q_next ^ m_in);
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit #(
   parameter int W          = 32,
   parameter int CARRY_MODE = divstep_pkg::CARRY_WIDE_ADDER
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_valid,
   input  logic [1:0]   cmd_code,
   input  logic [W-1:0] rem_in,
   input  logic [W-1:0] dvsr_in,
   output logic [W-1:0] rem_out,
   output logic         flag_q,
   output logic         flag_m,
   output logic         flag_t
);
   import divstep_pkg::*;

   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("divstep_unit: W must be at least 2");
      end
   endgenerate

   dstep_cmd_e   cmd;
   logic [W-1:0] shifted;
   logic         lost_bit;
   logic         do_sub;
   logic [W-1:0] sum;
   logic         carry;
   logic         q_step, t_step;

   assign cmd    = dstep_cmd_e'(cmd_code);
   assign do_sub = (flag_q == flag_m);

   divstep_shifter #(.W(W)) u_shift (
      .din      (rem_in),
      .fill_bit (flag_t),
      .dout     (shifted),
      .lost_bit (lost_bit)
   );

   divstep_addsub #(.W(W), .CARRY_MODE(CARRY_MODE)) u_addsub (
      .opa    (shifted),
      .opb    (dvsr_in),
      .do_sub (do_sub),
      .result (sum),
      .carry  (carry)
   );

   divstep_flags u_flags (
      .m_in     (flag_m),
      .lost_bit (lost_bit),
      .carry    (carry),
      .q_next   (q_step),
      .t_next   (t_step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_out <= '0;
         flag_q  <= 1'b0;
         flag_m  <= 1'b0;
         flag_t  <= 1'b0;
      end else if (cmd_valid) begin
         unique case (cmd)
            CMD_STEP: begin
               rem_out <= sum;
               flag_q  <= q_step;
               flag_t  <= t_step;
            end
            CMD_INIT_U: begin
               flag_q <= 1'b0;
               flag_m <= 1'b0;
               flag_t <= 1'b0;
            end
            CMD_INIT_S: begin
               flag_q <= rem_in[MSB];
               flag_m <= dvsr_in[MSB];
               flag_t <= rem_in[MSB] ^ dvsr_in[MSB];
            end
            CMD_ROT: begin
               rem_out <= shifted;
               flag_t  <= lost_bit;
            end
            default: ;
         endcase
      end
   end

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(rem_out) && $stable(flag_q) && $stable(flag_m) && $stable(flag_t)));

   // R2
   init_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd1) |=> (!flag_q && !flag_m && !flag_t && $stable(rem_out)));

   // R3
   init_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd2) |=>
         (flag_q == $past(rem_in[MSB]) && flag_m == $past(dvsr_in[MSB])
          && flag_t == (flag_q ^ flag_m) && $stable(rem_out)));

   // R6
   t_is_quotient_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd0) |=> (flag_t == (flag_q == flag_m) && $stable(flag_m)));

   // R7
   rotate_through_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd3) |=>
         (flag_t == $past(rem_in[MSB]) && rem_out[0] == $past(flag_t)
          && rem_out[MSB:1] == $past(rem_in[MSB-1:0]) && $stable(flag_q) && $stable(flag_m)));

   // R4
   step_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd0 && flag_q == flag_m) |=>
         (rem_out + $past(dvsr_in) == {$past(rem_in[MSB-1:0]), $past(flag_t)}));

endmodule

// File: tb/divstep_unit_tb.sv
`timescale 1ns/1ps
module divstep_unit_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [1:0]   cmd_code = 2'd0;
   logic [W-1:0] rem_in = '0;
   logic [W-1:0] dvsr_in = '0;
   logic [W-1:0] rem_out;
   logic         flag_q, flag_m, flag_t;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural model state
   logic [W-1:0] m_rem;
   logic         m_q, m_m, m_t;

   always #5 clk = ~clk;

   divstep_unit #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .rem_in(rem_in), .dvsr_in(dvsr_in), .rem_out(rem_out),
      .flag_q(flag_q), .flag_m(flag_m), .flag_t(flag_t)
   );

   task automatic compare(input string req);
      checks++;
      if (rem_out !== m_rem || flag_q !== m_q || flag_m !== m_m || flag_t !== m_t) begin
         errors++;
         $display("FAIL %s: rem=%h q=%b m=%b t=%b expected rem=%h q=%b m=%b t=%b",
                  req, rem_out, flag_q, flag_m, flag_t, m_rem, m_q, m_m, m_t);
      end
   endtask

   // Issue one command at a falling edge, update the model, check at the next falling edge.
   task automatic issue(input logic [1:0] code, input logic [W-1:0] a,
                        input logic [W-1:0] d, input string req);
      logic [W-1:0] s;
      logic [W:0]   wide;
      logic         c;
      cmd_valid = 1'b1;
      cmd_code  = code;
      rem_in    = a;
      dvsr_in   = d;
      case (code)
         2'd0: begin
            s = {a[W-2:0], m_t};
            if (m_q == m_m) begin
               wide = {1'b0, s} - {1'b0, d};
               c = (s < d);
            end else begin
               wide = {1'b0, s} + {1'b0, d};
               c = wide[W];
            end
            m_rem = wide[W-1:0];
            m_q = a[W-1] ^ c ^ m_m;
            m_t = (m_q == m_m);
         end
         2'd1: begin m_q = 0; m_m = 0; m_t = 0; end
         2'd2: begin m_q = a[W-1]; m_m = d[W-1]; m_t = a[W-1] ^ d[W-1]; end
         default: begin
            m_rem = {a[W-2:0], m_t};
            m_t = a[W-1];
         end
      endcase
      @(negedge clk);
      compare(req);
   endtask

   task automatic idle_cycle(input logic [W-1:0] a, input logic [W-1:0] d);
      cmd_valid = 1'b0;
      cmd_code  = 2'd0;
      rem_in    = a;
      dvsr_in   = d;
      @(negedge clk);
      compare("R8 idle hold");
   endtask

   task automatic divide_u(input logic [W-1:0] dividend, input logic [W-1:0] divisor);
      logic [W-1:0] hi, lo, expq;
      hi = '0;
      lo = dividend;
      issue(2'd1, '0, divisor, "R2 init-unsigned");
      for (int i = 0; i < W; i++) begin
         issue(2'd3, lo, divisor, "R7 rotate");
         lo = rem_out;
         issue(2'd0, hi, divisor, "R4/R5/R6 step");
         hi = rem_out;
      end
      issue(2'd3, lo, divisor, "R7 final rotate");
      lo = rem_out;
      expq = dividend / divisor;
      checks++;
      if (lo !== expq) begin
         errors++;
         $display("FAIL R9 quotient %0d/%0d: got %0d expected %0d", dividend, divisor, lo, expq);
      end
      cmd_valid = 1'b0;
   endtask

   initial begin
      m_rem = '0; m_q = 0; m_m = 0; m_t = 0;
      repeat (3) @(negedge clk);
      compare("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // signed initialisation, both sign combinations
      issue(2'd2, 32'h8000_0001, 32'h0000_0003, "R3 init-signed neg/pos");
      issue(2'd2, 32'h1234_5678, 32'hFFFF_FFF0, "R3 init-signed pos/neg");
      issue(2'd2, 32'hF000_0000, 32'h8000_0000, "R3 init-signed neg/neg");
      // steps under signed flags: add and subtract paths
      issue(2'd0, 32'hFFFF_FF00, 32'h8000_0000, "R4 step subtract");
      issue(2'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R5 step");
      issue(2'd2, 32'h0000_0010, 32'h8000_0005, "R3 init-signed pos/neg");
      issue(2'd0, 32'h0000_0010, 32'h8000_0005, "R4 step add");
      issue(2'd0, 32'hC000_0000, 32'hFFFF_FFFF, "R5 carry path");
      idle_cycle(32'hDEAD_BEEF, 32'h0BAD_F00D);
      idle_cycle(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      issue(2'd3, 32'hA5A5_A5A5, '0, "R7 rotate");
      issue(2'd1, 32'h8000_0000, 32'h8000_0000, "R2 init-unsigned");
      issue(2'd0, 32'h0000_0000, 32'h0000_0001, "R5 borrow");
      issue(2'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R6 step");

      divide_u(32'd100, 32'd7);
      divide_u(32'hFFFF_FFFF, 32'd1);
      divide_u(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      divide_u(32'd5, 32'd9);
      divide_u(32'h8000_0000, 32'd3);
      divide_u(32'd12345678, 32'h0001_0000);
      divide_u(32'hDEAD_BEEF, 32'h0000_1234);
      idle_cycle(32'h0, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule